// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Feedback Divider

This block divides a fast oscillator-rate clock by a ratio with an integer part and a fractional part. It emits one single-cycle feedback pulse per division cycle. The integer part comes from a dual-modulus prescaler driven by a swallow counter and a main counter. The prescaler is modelled here as a synchronous counter that runs P+1 cycles long during the swallow phase and P cycles long afterwards. A small accumulator adds the fractional numerator once per division cycle and wraps at a selectable modulus of 15 or 16. Each time the accumulator wraps, the division cycle gets exactly one extra oscillator cycle. Over a full accumulator period, the mean pulse spacing is therefore N + num/mod.

A four-state machine sequences each division cycle:
- **OFF**: the divider is held in reset or power-down.
- **SWALLOW**: the prescaler runs at P+1.
- **MAIN**: the prescaler runs at P.
- **EXTRA**: the one-cycle stretch added when the accumulator wraps.

The machine has these transitions:
- OFF→SWALLOW or OFF→MAIN when the hold is released (start).
- SWALLOW→MAIN after A prescaler cycles (swallow done).
- MAIN→EXTRA at the end of the B-th prescaler cycle when a wrap is pending (stretch).
- MAIN→SWALLOW or MAIN→MAIN at that same point when no wrap is pending (restart).
- EXTRA→SWALLOW or EXTRA→MAIN (restart).
- Any state→OFF on reset or power-down (hold).

Restart and start enter SWALLOW when the newly sampled A is non-zero, and MAIN otherwise. The divider samples A, B, the prescaler select and the fraction only on start and restart edges.

Top module: `fracn_fb_divider`

## Requirements
- R1: With `frac_num`=0, consecutive `fb_pulse` assertions are exactly N = P×B + A clock cycles apart. P is 16 when `psc_wide`=0 and 32 when `psc_wide`=1. This holds for any legal setting: B ≥ 3, B ≥ A+2, and A < P.
- R2: Each division cycle lasts either N or N+1 clock cycles, never any other length.
- R3: With `frac_mod16`=1 (modulus 16), any 16 consecutive division cycles span exactly 16×N + `frac_num` clock cycles. The numerator can be any value from 0 to 15.
- R4: With `frac_mod16`=0 (modulus 15), any 15 consecutive division cycles span exactly 15×N + `frac_num` clock cycles. The numerator can be any value from 0 to 14.
- R5: With modulus 15 and `frac_num`=15, every division cycle lasts N+1 cycles, including the first one after reset.
- R6: A change of A, B, `psc_wide` or the fraction made right after a pulse does not alter the division cycle already under way. It applies from the following cycle.
- R7: While `rst` is high at a clock edge, `fb_pulse` is low. After `rst` is released with `frac_num`=0, the first pulse is seen N+1 edges later, counting the first edge with `rst` low as edge 1.
- R8: While `pwr_dn` is high, `fb_pulse` stays low and all counters are held cleared. After release, the first pulse follows with the same N+1 latency as in R7.
- R9: `fb_pulse` is high for exactly one clock cycle per division cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock being divided |
| rst | input | 1 | Synchronous counter reset, active high |
| pwr_dn | input | 1 | Power-down hold, active high; clears and holds all counters |
| psc_wide | input | 1 | Prescaler select: 0 for P=16, 1 for P=32 |
| swallow_a | input | 5 | Swallow count A |
| main_b | input | 10 | Main count B |
| frac_num | input | 4 | Fractional numerator |
| frac_mod16 | input | 1 | Fractional modulus: 1 for 16, 0 for 15 |
| fb_pulse | output | 1 | One-cycle feedback pulse per division cycle |

## Verification
The integer path is tried with three patterns:
- A mid-range setting with P=16.
- A maximum-swallow setting with P=32, which exercises the long swallow phase and the wide prescaler.
- A=0, which skips SWALLOW entirely and distinguishes the two start paths.

The fractional path is tried with four patterns:
- An odd numerator over 16.
- An odd numerator over 15.
- A full 15/15 fraction, which stretches every cycle.
- 15/16, where exactly one cycle in sixteen is unstretched.

Together these separate a wrong wrap threshold, a lost or doubled carry, and a carry applied to the wrong cycle. The remaining patterns each target one behaviour:
- A mid-run change of B tests the cycle-boundary sampling.
- Power-down and reset issued mid-run test the clear-and-restart latency.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2,
        ST_EXTRA   = 2'd3
    } div_state_e;

endpackage

// File: rtl/fracn_prescaler.sv
module fracn_prescaler #(
    parameter int P_LO = 16,
    parameter int P_HI = 32,
    localparam int CW  = $clog2(P_HI + 2)
) (
    input  logic clk,
    input  logic clr,
    input  logic en,
    input  logic wide,
    input  logic swallow,
    output logic tc
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_v;

    // cycle-level model of the dual-modulus divider: length P or P+1
    always_comb begin
        last_v = wide ? CW'(P_HI) : CW'(P_LO);
        if (!swallow) begin
            last_v = last_v - CW'(1);
        end
        tc = en && (cnt_q == last_v);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= tc ? '0 : cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/fracn_blk_ctr.sv
module fracn_blk_ctr #(
    parameter int BW = 10
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          adv,
    input  logic          wrap,
    output logic [BW-1:0] cnt_q
);

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= wrap ? '0 : cnt_q + BW'(1);
        end
    end

endmodule

// File: rtl/fracn_accum.sv
module fracn_accum #(
    parameter int FW  = 4,
    localparam int SW = FW + 1
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          step,
    input  logic [FW-1:0] num,
    input  logic          mod16,
    output logic          carry_q
);

    logic [FW-1:0] acc_q;
    logic [SW-1:0] sum_v;
    logic [SW-1:0] mod_v;
    logic          carry_v;

    always_comb begin
        sum_v   = {1'b0, acc_q} + {1'b0, num};
        mod_v   = mod16 ? SW'(2 ** FW) : SW'(2 ** FW - 1);
        carry_v = (sum_v >= mod_v);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else if (step) begin
            acc_q   <= carry_v ? FW'(sum_v - mod_v) : FW'(sum_v);
            carry_q <= carry_v;
        end
    end

endmodule

// File: rtl/fracn_fb_divider.sv
module fracn_fb_divider
    import fracn_pkg::*;
#(
    parameter int A_W  = 5,
    parameter int B_W  = 10,
    parameter int F_W  = 4,
    parameter int P_LO = 16,
    parameter int P_HI = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pwr_dn,
    input  logic           psc_wide,
    input  logic [A_W-1:0] swallow_a,
    input  logic [B_W-1:0] main_b,
    input  logic [F_W-1:0] frac_num,
    input  logic           frac_mod16,
    output logic           fb_pulse
);

    div_state_e     state_q, state_n;
    logic           hold;
    logic           pre_tc;
    logic [B_W-1:0] blk_cnt;
    logic           carry_q;
    logic [A_W-1:0] sh_a;
    logic [B_W-1:0] sh_b;
    logic           sh_wide;
    logic           swallow_last;
    logic           blk_last;
    logic           main_end;
    logic           end_div;
    logic           load;
    div_state_e     entry_st;

    assign hold = rst | pwr_dn;

    fracn_prescaler #(.P_LO(P_LO), .P_HI(P_HI)) u_presc (
        .clk     (clk),
        .clr     (hold),
        .en      ((state_q == ST_SWALLOW) || (state_q == ST_MAIN)),
        .wide    (sh_wide),
        .swallow (state_q == ST_SWALLOW),
        .tc      (pre_tc)
    );

    fracn_blk_ctr #(.BW(B_W)) u_blk (
        .clk   (clk),
        .clr   (hold),
        .adv   (pre_tc),
        .wrap  (blk_last),
        .cnt_q (blk_cnt)
    );

    fracn_accum #(.FW(F_W)) u_acc (
        .clk     (clk),
        .clr     (hold),
        .step    (load),
        .num     (frac_num),
        .mod16   (frac_mod16),
        .carry_q (carry_q)
    );

    always_comb begin
        swallow_last = (blk_cnt == (B_W'(sh_a) - B_W'(1)));
        blk_last     = (blk_cnt == (sh_b - B_W'(1)));
        main_end     = (state_q == ST_MAIN) && pre_tc && blk_last;
        end_div      = (main_end && !carry_q) || (state_q == ST_EXTRA);
        load         = !hold && ((state_q == ST_OFF) || end_div);
        entry_st     = (swallow_a != '0) ? ST_SWALLOW : ST_MAIN;
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_OFF:     state_n = entry_st;
            ST_SWALLOW: if (pre_tc && swallow_last) state_n = ST_MAIN;
            ST_MAIN: begin
                if (main_end) begin
                    state_n = carry_q ? ST_EXTRA : entry_st;
                end
            end
            ST_EXTRA:   state_n = entry_st;
            default:    state_n = ST_OFF;
        endcase
        if (hold) begin
            state_n = ST_OFF;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        state_q <= state_n;
    end

    // shadow copy of the integer setting, refreshed only at a boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_a    <= '0;
            sh_b    <= '0;
            sh_wide <= 1'b0;
        end else if (load) begin
            sh_a    <= swallow_a;
            sh_b    <= main_b;
            sh_wide <= psc_wide;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (hold) begin
            fb_pulse <= 1'b0;
        end else begin
            fb_pulse <= end_div;
        end
    end

endmodule

// File: rtl/fracn_fb_divider_chk.sv
module fracn_fb_divider_chk
    import fracn_pkg::*;
#(
    parameter int A_W = 5,
    parameter int B_W = 10
) (
    input logic           clk,
    input logic           rst,
    input logic           pwr_dn,
    input logic           fb_pulse,
    input div_state_e     state_q,
    input logic           carry_q,
    input logic [B_W-1:0] blk_cnt,
    input logic [A_W-1:0] sh_a,
    input logic [B_W-1:0] sh_b,
    input logic           load
);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fb_pulse |=> !fb_pulse); // R9

    AST_PWRDN_QUIET: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> !fb_pulse); // R8

    AST_EXTRA_NEEDS_CARRY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXTRA) |-> carry_q); // R3

    AST_SWALLOW_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SWALLOW) |-> (blk_cnt < B_W'(sh_a))); // R1

    AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(sh_b)); // R6

endmodule

bind fracn_fb_divider fracn_fb_divider_chk #(.A_W(A_W), .B_W(B_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .pwr_dn   (pwr_dn),
    .fb_pulse (fb_pulse),
    .state_q  (state_q),
    .carry_q  (carry_q),
    .blk_cnt  (blk_cnt),
    .sh_a     (sh_a),
    .sh_b     (sh_b),
    .load     (load)
);

// File: tb/fracn_fb_divider_tb.sv
`timescale 1ns/1ps
module fracn_fb_divider_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_dn = 1'b0;
    logic       psc_wide = 1'b0;
    logic [4:0] swallow_a = 5'd0;
    logic [9:0] main_b = 10'd3;
    logic [3:0] frac_num = 4'd0;
    logic       frac_mod16 = 1'b1;
    logic       fb_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fracn_fb_divider dut_i (
        .clk        (clk),
        .rst        (rst),
        .pwr_dn     (pwr_dn),
        .psc_wide   (psc_wide),
        .swallow_a  (swallow_a),
        .main_b     (main_b),
        .frac_num   (frac_num),
        .frac_mod16 (frac_mod16),
        .fb_pulse   (fb_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int n_of(input bit w, input int a, input int b);
        return (w ? 32 : 16) * b + a;
    endfunction

    // counts falling edges up to and including the one where the pulse is seen
    task automatic wait_pulse(output int edges);
        edges = 0;
        do begin
            @(negedge clk);
            edges++;
        end while (!fb_pulse && edges < 5000);
    endtask

    task automatic setup(input bit w, input int a, input int b, input int num, input bit m16);
        @(negedge clk);
        rst        = 1'b1;
        psc_wide   = w;
        swallow_a  = 5'(a);
        main_b     = 10'(b);
        frac_num   = 4'(num);
        frac_mod16 = m16;
        repeat (3) @(negedge clk);
        check(fb_pulse == 1'b0, "R7 pulse low in reset", fb_pulse, 0);
        rst = 1'b0;
    endtask

    task automatic run_integer(input bit w, input int a, input int b);
        int e;
        int n;
        n = n_of(w, a, b);
        setup(w, a, b, 0, 1'b1);
        wait_pulse(e);
        check(e == n + 1, "R7 first pulse latency", e, n + 1);
        for (int k = 0; k < 3; k++) begin
            wait_pulse(e);
            check(e == n, "R1 integer period", e, n);
        end
        @(negedge clk);
        check(fb_pulse == 1'b0, "R9 pulse width one cycle", fb_pulse, 0);
    endtask

    task automatic run_fraction(input int num, input bit m16, input string req);
        int e;
        int sum;
        int n;
        int m;
        n   = n_of(1'b0, 5, 20);
        m   = m16 ? 16 : 15;
        sum = 0;
        setup(1'b0, 5, 20, num, m16);
        wait_pulse(e);
        for (int k = 0; k < m; k++) begin
            wait_pulse(e);
            sum += e;
            check(e == n || e == n + 1, "R2 period is N or N+1", e, n);
        end
        check(sum == m * n + num, req, sum, m * n + num);
    endtask

    task automatic run_full_fraction;
        int e;
        int n;
        n = n_of(1'b0, 5, 20);
        setup(1'b0, 5, 20, 15, 1'b0);
        wait_pulse(e);
        check(e == n + 2, "R5 first cycle stretched", e, n + 2);
        for (int k = 0; k < 4; k++) begin
            wait_pulse(e);
            check(e == n + 1, "R5 every cycle stretched", e, n + 1);
        end
    endtask

    task automatic run_midchange;
        int e;
        setup(1'b0, 3, 10, 0, 1'b1);
        wait_pulse(e);
        main_b = 10'd12;
        wait_pulse(e);
        check(e == n_of(1'b0, 3, 10), "R6 running cycle keeps old B", e, n_of(1'b0, 3, 10));
        wait_pulse(e);
        check(e == n_of(1'b0, 3, 12), "R6 next cycle uses new B", e, n_of(1'b0, 3, 12));
    endtask

    task automatic run_powerdown;
        int e;
        int seen;
        int n;
        n = n_of(1'b0, 4, 9);
        setup(1'b0, 4, 9, 0, 1'b1);
        wait_pulse(e);
        repeat (37) @(negedge clk);
        pwr_dn = 1'b1;
        seen   = 0;
        repeat (400) begin
            @(negedge clk);
            if (fb_pulse) seen++;
        end
        check(seen == 0, "R8 no pulse in power-down", seen, 0);
        pwr_dn = 1'b0;
        wait_pulse(e);
        check(e == n + 1, "R8 restart latency after power-down", e, n + 1);
        wait_pulse(e);
        check(e == n, "R8 period after power-down", e, n);
    endtask

    task automatic run_midreset;
        int e;
        int n;
        n = n_of(1'b1, 2, 5);
        setup(1'b1, 2, 5, 0, 1'b1);
        wait_pulse(e);
        repeat (50) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(fb_pulse == 1'b0, "R7 pulse low in mid-run reset", fb_pulse, 0);
        rst = 1'b0;
        wait_pulse(e);
        check(e == n + 1, "R7 restart latency after reset", e, n + 1);
    endtask

    initial begin
        run_integer(1'b0, 5, 20);
        run_integer(1'b1, 31, 33);
        run_integer(1'b0, 0, 3);
        run_fraction(5, 1'b1, "R3 mod-16 average");
        run_fraction(15, 1'b1, "R3 mod-16 numerator 15");
        run_fraction(7, 1'b0, "R4 mod-15 average");
        run_full_fraction();
        run_midchange();
        run_powerdown();
        run_midreset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule